// File: doc/BRIEF.md
# Software-Managed Translation Lookaside Buffer

This block is a small, fully associative address translation buffer whose contents are maintained entirely by software. Software stages a candidate entry in a set of working registers: a slot selector, a tag word (virtual page number plus address-space identifier), a page-size word and two opaque payload words. It then issues one of four commands: load the entry at the selected slot into the working registers, store the working registers at the selected slot, store them at a pseudo-random slot, or search for an entry that matches the tag word.

Each entry covers an even/odd pair of pages. The page size can be set per entry from 1 KB up to 256 MB, and a small-page mode, active only when a capability input and an enable input are both high, permits the 1 KB size. The entry keeps its page-size mask together with the shift amount, compare-ignore mask and offset mask decoded from it when it was written. A separate combinational port translates a virtual address in the same cycle. It returns the payload of the even or odd page, the in-page offset and the matching slot, and flags misses and multiple matches.

Top module: `soft_tlb`

## Requirements
- R1: After reset the slot selector, tag word, size word, payload words and err_o are zero, rnd_o equals ENTRIES-1 and every entry is invalid, so any lookup misses.
- R2: A register write (reg_we_i with cmd_valid_i low) updates the addressed working register at the next clock edge. The addresses are 0 selector, 1 tag, 2 size, 3 even payload, 4 odd payload. A register write presented in the same cycle as a command is ignored.
- R3: Command code 1 (store-indexed) writes the entry at slot sel[log2(ENTRIES)-1:0] and ignores selector bit 31. It stores the VPN from tag[31:11], the ASID from tag[ASID_W-1:0], the size mask from size[28:11] and both payloads.
- R4: Command code 2 (store-random) writes the entry at the slot shown on rnd_o in the cycle the command is presented. rnd_o counts down by one every clock and reloads ENTRIES-1 after reaching 0.
- R5: Command code 0 (load) copies the selected entry into the working registers. The tag word becomes VPN in bits 31:11 and ASID in bits ASID_W-1:0, with all other bits zero. The size word becomes the stored mask at bits 28:11.
- R6: When small-page mode is off, a load returns size-word bits 12:11 as zero. When it is on, they return as stored.
- R7: Small-page mode is on only when sp_cap_i and sp_en_i are both 1. It fixes the page size and ignore mask of entries stored at that time, and it controls whether a search ignores the two lowest VPN bits.
- R8: The legal size masks are (1<<2k)-1 for k = 0..9. A store with any other mask leaves every entry unchanged and raises err_o for exactly the one cycle after the command.
- R9: Command code 3 (search) compares the tag word's VPN and ASID against all valid entries. Outside small-page mode it ignores the two lowest VPN bits (address bits 12:11). A hit writes the lowest matching slot number into the selector with bit 31 clear. A miss writes 0x8000_0000.
- R10: An entry's page shift is 10+2k, and never less than 12 outside small-page mode. A lookup hits when its ASID matches and address bits 31 down to shift+1 equal the same bits of the entry's VPN.
- R11: On a lookup hit, lk_data_o is the odd payload if address bit [shift] is 1 and the even payload otherwise. lk_off_o is the address ANDed with (1<<shift)-1, and lk_idx_o is the matching slot.
- R12: lk_miss_o is high in the same cycle as lk_valid_i when no valid entry matches, and lk_hit_o is high when one does. Both are low while lk_valid_i is low.
- R13: When more than one entry matches a lookup, lk_multi_o and lk_hit_o are high and lk_idx_o is the lowest matching slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Working-register write strobe |
| reg_addr_i | input | 3 | Working-register address |
| reg_wdata_i | input | 32 | Working-register write data |
| sp_cap_i | input | 1 | Small-page capability |
| sp_en_i | input | 1 | Small-page enable |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code (0 load, 1 store-indexed, 2 store-random, 3 search) |
| sel_o | output | 32 | Slot selector register |
| tag_o | output | 32 | Tag word (VPN and ASID) |
| size_o | output | 32 | Page-size word |
| lo0_o | output | DATA_W | Even-page payload register |
| lo1_o | output | DATA_W | Odd-page payload register |
| rnd_o | output | log2(ENTRIES) | Pseudo-random slot |
| err_o | output | 1 | Illegal size mask on a store |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_asid_i | input | ASID_W | Lookup address-space identifier |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup miss |
| lk_multi_o | output | 1 | More than one entry matched |
| lk_idx_o | output | log2(ENTRIES) | Matching slot |
| lk_data_o | output | DATA_W | Selected page payload |
| lk_off_o | output | 32 | In-page offset |

## Verification
The assertions check these properties on every cycle:
- The random slot always steps down by one and wraps.
- err_o only follows a store command.
- A search leaves the selector either as a valid slot number or as the exact miss code.
- Hit, miss and multi-hit are mutually consistent.
- Idle working registers hold their values.
- A load outside small-page mode clears size bits 12:11.

Only the bench's scenarios can show that translation is correct. These cover payload and offset selection across 4 KB, 16 KB, 256 MB and 1 KB pages, the effect of the mode bits on search and lookup, the rejection of illegal masks without corrupting the stored entry, and the placement of a random store.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

    // Address bits 31:11 form the stored page number, bits 28:11 the size mask.
    localparam int VPN_W  = 21;
    localparam int MASK_W = 18;
    localparam int NPAT   = MASK_W / 2 + 1;

    typedef enum logic [1:0] {
        OP_LOAD      = 2'd0,
        OP_STORE_IDX = 2'd1,
        OP_STORE_RND = 2'd2,
        OP_SEARCH    = 2'd3
    } tlb_op_e;

    typedef enum logic [2:0] {
        RA_SEL  = 3'd0,
        RA_TAG  = 3'd1,
        RA_SIZE = 3'd2,
        RA_LO0  = 3'd3,
        RA_LO1  = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/soft_tlb_mask_decode.sv
module soft_tlb_mask_decode
    import soft_tlb_pkg::*;
(
    input  logic [MASK_W-1:0] mask_i,
    input  logic              small_i,
    output logic              legal_o,
    output logic [4:0]        shift_o,
    output logic [VPN_W-1:0]  ign_o,
    output logic [31:0]       offm_o
);

    logic [NPAT-1:0] pat_hit;

    // One comparator per legal contiguous pattern of paired ones.
    for (genvar k = 0; k < NPAT; k++) begin : g_pat
        assign pat_hit[k] = (mask_i == MASK_W'((64'd1 << (2 * k)) - 64'd1));
    end

    logic [4:0] pairs;

    always_comb begin
        pairs = '0;
        for (int k = 0; k < NPAT; k++) begin
            if (pat_hit[k]) pairs = 5'(k);
        end
        legal_o = |pat_hit;
        shift_o = 5'd10 + {pairs[3:0], 1'b0};
        if (!small_i && shift_o < 5'd12) shift_o = 5'd12;
        ign_o   = VPN_W'(mask_i) | (small_i ? VPN_W'(0) : VPN_W'(3));
        offm_o  = (32'd1 << shift_o) - 32'd1;
    end

endmodule

// File: rtl/soft_tlb_match.sv
module soft_tlb_match
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]              vld_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   ign_i,
    input  logic [ENTRIES-1:0][ASID_W-1:0]  asid_i,
    input  logic [VPN_W-1:0]                key_vpn_i,
    input  logic [VPN_W-1:0]                key_ign_i,
    input  logic [ASID_W-1:0]               key_asid_i,
    output logic [ENTRIES-1:0]              hit_o,
    output logic [$clog2(ENTRIES)-1:0]      idx_o,
    output logic                            any_o,
    output logic                            multi_o
);

    localparam int IDX_W = $clog2(ENTRIES);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_o[e] = vld_i[e]
                       && (asid_i[e] == key_asid_i)
                       && (((vpn_i[e] ^ key_vpn_i) & ~(ign_i[e] | key_ign_i)) == '0);
    end

    always_comb begin
        idx_o = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (hit_o[e]) idx_o = IDX_W'(e);
        end
        any_o   = |hit_o;
        multi_o = (hit_o & (hit_o - ENTRIES'(1))) != '0;
    end

endmodule

// File: rtl/soft_tlb_rand.sv
module soft_tlb_rand #(
    parameter int ENTRIES = 8
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    output logic [$clog2(ENTRIES)-1:0]  slot_o
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == '0) ? IDX_W'(ENTRIES - 1) : cnt_q - IDX_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= IDX_W'(ENTRIES - 1);
        else         cnt_q <= cnt_d;
    end

    assign slot_o = cnt_q;

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        reg_we_i,
    input  logic [2:0]                  reg_addr_i,
    input  logic [31:0]                 reg_wdata_i,
    input  logic                        sp_cap_i,
    input  logic                        sp_en_i,
    input  logic                        cmd_valid_i,
    input  logic [1:0]                  cmd_op_i,
    output logic [31:0]                 sel_o,
    output logic [31:0]                 tag_o,
    output logic [31:0]                 size_o,
    output logic [DATA_W-1:0]           lo0_o,
    output logic [DATA_W-1:0]           lo1_o,
    output logic [$clog2(ENTRIES)-1:0]  rnd_o,
    output logic                        err_o,
    input  logic                        lk_valid_i,
    input  logic [31:0]                 lk_va_i,
    input  logic [ASID_W-1:0]           lk_asid_i,
    output logic                        lk_hit_o,
    output logic                        lk_miss_o,
    output logic                        lk_multi_o,
    output logic [$clog2(ENTRIES)-1:0]  lk_idx_o,
    output logic [DATA_W-1:0]           lk_data_o,
    output logic [31:0]                 lk_off_o
);

    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [31:0]                       sel;
        logic [31:0]                       tag;
        logic [31:0]                       size;
        logic [DATA_W-1:0]                 lo0;
        logic [DATA_W-1:0]                 lo1;
        logic                              err;
        logic [ENTRIES-1:0]                vld;
        logic [ENTRIES-1:0][VPN_W-1:0]     vpn;
        logic [ENTRIES-1:0][VPN_W-1:0]     ign;
        logic [ENTRIES-1:0][ASID_W-1:0]    asid;
        logic [ENTRIES-1:0][MASK_W-1:0]    mask;
        logic [ENTRIES-1:0][4:0]           shift;
        logic [ENTRIES-1:0][31:0]          offm;
        logic [ENTRIES-1:0][DATA_W-1:0]    e_lo0;
        logic [ENTRIES-1:0][DATA_W-1:0]    e_lo1;
    } state_t;

    state_t s_d, s_q;

    logic small_mode;
    assign small_mode = sp_cap_i & sp_en_i;

    // Random slot source
    logic [IDX_W-1:0] rnd_slot;

    soft_tlb_rand #(.ENTRIES(ENTRIES)) u_rand (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .slot_o (rnd_slot)
    );

    // Decode of the staged size mask
    logic              dec_legal;
    logic [4:0]        dec_shift;
    logic [VPN_W-1:0]  dec_ign;
    logic [31:0]       dec_offm;

    soft_tlb_mask_decode u_dec (
        .mask_i  (s_q.size[28:11]),
        .small_i (small_mode),
        .legal_o (dec_legal),
        .shift_o (dec_shift),
        .ign_o   (dec_ign),
        .offm_o  (dec_offm)
    );

    // Search comparator array, keyed by the tag register
    logic [ENTRIES-1:0] pr_hits;
    logic [IDX_W-1:0]   pr_idx;
    logic               pr_any;
    logic               pr_multi;

    soft_tlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W)) u_probe (
        .vld_i      (s_q.vld),
        .vpn_i      (s_q.vpn),
        .ign_i      (s_q.ign),
        .asid_i     (s_q.asid),
        .key_vpn_i  (s_q.tag[31:11]),
        .key_ign_i  (small_mode ? VPN_W'(0) : VPN_W'(3)),
        .key_asid_i (s_q.tag[ASID_W-1:0]),
        .hit_o      (pr_hits),
        .idx_o      (pr_idx),
        .any_o      (pr_any),
        .multi_o    (pr_multi)
    );

    // Lookup comparator array, keyed by the translation port
    logic [ENTRIES-1:0] lk_hits;
    logic [IDX_W-1:0]   lk_idx;
    logic               lk_any;
    logic               lk_many;

    soft_tlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W)) u_lookup (
        .vld_i      (s_q.vld),
        .vpn_i      (s_q.vpn),
        .ign_i      (s_q.ign),
        .asid_i     (s_q.asid),
        .key_vpn_i  (lk_va_i[31:11]),
        .key_ign_i  (VPN_W'(0)),
        .key_asid_i (lk_asid_i),
        .hit_o      (lk_hits),
        .idx_o      (lk_idx),
        .any_o      (lk_any),
        .multi_o    (lk_many)
    );

    // Next-state computation
    logic [IDX_W-1:0] sel_slot;
    logic [IDX_W-1:0] wr_slot;

    always_comb begin
        s_d      = s_q;
        s_d.err  = 1'b0;
        sel_slot = s_q.sel[IDX_W-1:0];
        wr_slot  = (tlb_op_e'(cmd_op_i) == OP_STORE_RND) ? rnd_slot : sel_slot;

        if (cmd_valid_i) begin
            unique case (tlb_op_e'(cmd_op_i))
                OP_LOAD: begin
                    s_d.tag                = '0;
                    s_d.tag[31:11]         = s_q.vpn[sel_slot];
                    s_d.tag[ASID_W-1:0]    = s_q.asid[sel_slot];
                    s_d.size               = '0;
                    s_d.size[28:11]        = s_q.mask[sel_slot];
                    if (!small_mode) s_d.size[12:11] = 2'b00;
                    s_d.lo0                = s_q.e_lo0[sel_slot];
                    s_d.lo1                = s_q.e_lo1[sel_slot];
                end
                OP_STORE_IDX, OP_STORE_RND: begin
                    if (dec_legal) begin
                        s_d.vld[wr_slot]   = 1'b1;
                        s_d.vpn[wr_slot]   = s_q.tag[31:11];
                        s_d.asid[wr_slot]  = s_q.tag[ASID_W-1:0];
                        s_d.mask[wr_slot]  = s_q.size[28:11];
                        s_d.shift[wr_slot] = dec_shift;
                        s_d.ign[wr_slot]   = dec_ign;
                        s_d.offm[wr_slot]  = dec_offm;
                        s_d.e_lo0[wr_slot] = s_q.lo0;
                        s_d.e_lo1[wr_slot] = s_q.lo1;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
                OP_SEARCH: begin
                    s_d.sel = pr_any ? 32'(pr_idx) : 32'h8000_0000;
                end
                default: ;
            endcase
        end else if (reg_we_i) begin
            case (reg_addr_e'(reg_addr_i))
                RA_SEL:  s_d.sel  = reg_wdata_i;
                RA_TAG:  s_d.tag  = reg_wdata_i;
                RA_SIZE: s_d.size = reg_wdata_i;
                RA_LO0:  s_d.lo0  = DATA_W'(reg_wdata_i);
                RA_LO1:  s_d.lo1  = DATA_W'(reg_wdata_i);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // Translation outputs
    logic [4:0] lk_shift;
    logic       lk_odd;

    always_comb begin
        lk_shift   = s_q.shift[lk_idx];
        lk_odd     = lk_va_i[lk_shift];
        lk_hit_o   = lk_valid_i && lk_any;
        lk_miss_o  = lk_valid_i && !lk_any;
        lk_multi_o = lk_valid_i && lk_many;
        lk_idx_o   = lk_hit_o ? lk_idx : '0;
        lk_data_o  = '0;
        lk_off_o   = '0;
        if (lk_hit_o) begin
            lk_data_o = lk_odd ? s_q.e_lo1[lk_idx] : s_q.e_lo0[lk_idx];
            lk_off_o  = lk_va_i & s_q.offm[lk_idx];
        end
    end

    assign sel_o  = s_q.sel;
    assign tag_o  = s_q.tag;
    assign size_o = s_q.size;
    assign lo0_o  = s_q.lo0;
    assign lo1_o  = s_q.lo1;
    assign err_o  = s_q.err;
    assign rnd_o  = rnd_slot;

endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk #(
    parameter int ENTRIES = 8
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        reg_we_i,
    input logic                        sp_cap_i,
    input logic                        sp_en_i,
    input logic                        cmd_valid_i,
    input logic [1:0]                  cmd_op_i,
    input logic [31:0]                 sel_o,
    input logic [31:0]                 tag_o,
    input logic [31:0]                 size_o,
    input logic [$clog2(ENTRIES)-1:0]  rnd_o,
    input logic                        err_o,
    input logic                        lk_valid_i,
    input logic                        lk_hit_o,
    input logic                        lk_miss_o,
    input logic                        lk_multi_o
);

    localparam int IDX_W = $clog2(ENTRIES);

    p_rnd_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> rnd_o == (($past(rnd_o) == '0) ? IDX_W'(ENTRIES - 1) : $past(rnd_o) - IDX_W'(1)));

    p_err_after_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(cmd_valid_i && (cmd_op_i == 2'd1 || cmd_op_i == 2'd2)));

    p_search_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == 2'd3) |=>
            (sel_o[31] ? (sel_o[30:0] == '0) : (sel_o < 32'(ENTRIES))));

    p_miss_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_miss_o |-> (!lk_hit_o && !lk_multi_o));

    p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_valid_i |-> (!lk_hit_o && !lk_miss_o));

    p_multi_hit_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_multi_o |-> lk_hit_o);

    p_regs_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cmd_valid_i && !reg_we_i) |=> ($stable(tag_o) && $stable(size_o) && $stable(sel_o)));

    p_load_size_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == 2'd0 && !(sp_cap_i && sp_en_i)) |=> (size_o[12:11] == 2'b00));

endmodule

bind soft_tlb soft_tlb_chk #(.ENTRIES(ENTRIES)) u_soft_tlb_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .sp_cap_i    (sp_cap_i),
    .sp_en_i     (sp_en_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .sel_o       (sel_o),
    .tag_o       (tag_o),
    .size_o      (size_o),
    .rnd_o       (rnd_o),
    .err_o       (err_o),
    .lk_valid_i  (lk_valid_i),
    .lk_hit_o    (lk_hit_o),
    .lk_miss_o   (lk_miss_o),
    .lk_multi_o  (lk_multi_o)
);

// File: tb/tb_soft_tlb.sv
module tb_soft_tlb;

    localparam int ENTRIES = 8;
    localparam int ASID_W  = 8;
    localparam int DATA_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic              sp_cap = 1'b0;
    logic              sp_en = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = '0;
    logic [31:0]       sel, tag, size;
    logic [DATA_W-1:0] lo0, lo1;
    logic [2:0]        rnd;
    logic              err;
    logic              lk_valid = 1'b0;
    logic [31:0]       lk_va = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              lk_hit, lk_miss, lk_multi;
    logic [2:0]        lk_idx;
    logic [DATA_W-1:0] lk_data;
    logic [31:0]       lk_off;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    soft_tlb #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .DATA_W(DATA_W)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .sp_cap_i(sp_cap), .sp_en_i(sp_en),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .sel_o(sel), .tag_o(tag), .size_o(size), .lo0_o(lo0), .lo1_o(lo1),
        .rnd_o(rnd), .err_o(err),
        .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_asid_i(lk_asid),
        .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_multi_o(lk_multi),
        .lk_idx_o(lk_idx), .lk_data_o(lk_data), .lk_off_o(lk_off)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic put(input logic [31:0] s, input logic [31:0] t, input logic [31:0] z,
                       input logic [31:0] a, input logic [31:0] b);
        wr_reg(3'd0, s); wr_reg(3'd1, t); wr_reg(3'd2, z);
        wr_reg(3'd3, a); wr_reg(3'd4, b);
        do_cmd(2'd1);
    endtask

    task automatic load(input logic [31:0] s);
        wr_reg(3'd0, s);
        do_cmd(2'd0);
    endtask

    task automatic search(input logic [31:0] t);
        wr_reg(3'd1, t);
        do_cmd(2'd3);
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid;
        #1;
    endtask

    task automatic t_reset;
        chk("R1 sel", sel, 0);
        chk("R1 tag", tag, 0);
        chk("R1 size", size, 0);
        chk("R1 lo0", lo0, 0);
        chk("R1 err", err, 0);
        chk("R1 rnd", rnd, 7);
        look(32'h0, 8'h0);
        chk("R1 empty lookup misses", lk_miss, 1);
        lk_valid = 1'b0;
    endtask

    task automatic t_store_load;
        sp_cap = 1'b1; sp_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            put(32'h8000_0000 | 32'(i), 32'h0010_0000 + 32'(i) * 32'h2000 + 32'(i + 1),
                32'h0, 32'hA000_0000 + 32'(i), 32'hB000_0000 + 32'(i));
        end
        wr_reg(3'd1, 32'h0); wr_reg(3'd3, 32'h0); wr_reg(3'd4, 32'h0);
        load(32'h8000_0002);
        chk("R3/R5 tag of slot 2", tag, 32'h0010_4003);
        chk("R5 size of slot 2", size, 32'h0);
        chk("R3/R5 lo0 of slot 2", lo0, 32'hA000_0002);
        chk("R3/R5 lo1 of slot 2", lo1, 32'hB000_0002);
        // R2: register write in the same cycle as a command is dropped
        wr_reg(3'd0, 32'h1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0;
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'hDEAD_0000;
        @(negedge clk);
        cmd_valid = 1'b0; reg_we = 1'b0;
        chk("R2 write during command ignored", tag, 32'h0010_2002);
        wr_reg(3'd3, 32'h1234_5678);
        chk("R2 payload register write", lo0, 32'h1234_5678);
    endtask

    task automatic t_size_mode;
        sp_cap = 1'b1; sp_en = 1'b0;
        put(32'h4, 32'h0200_0004, 32'h0000_1800, 32'h0, 32'h0);
        load(32'h4);
        chk("R6 normal mode clears size 12:11", size, 32'h0);
        sp_en = 1'b1;
        load(32'h4);
        chk("R6 small mode keeps size 12:11", size, 32'h0000_1800);
        sp_cap = 1'b0;
        load(32'h4);
        chk("R7 enable without capability is normal", size, 32'h0);
        sp_en = 1'b0;
    endtask

    task automatic t_lookup;
        put(32'h5, 32'h4000_0022, 32'h0000_7800, 32'h1111_0000, 32'h2222_0000);
        put(32'h6, 32'h8000_0022, 32'h1FFF_F800, 32'h3333, 32'h4444);
        look(32'h4000_4123, 8'h22);
        chk("R10 16KB hit", lk_hit, 1);
        chk("R11 16KB index", lk_idx, 5);
        chk("R11 16KB odd payload", lk_data, 32'h2222_0000);
        chk("R11 16KB offset", lk_off, 32'h0123);
        look(32'h4000_2ABC, 8'h22);
        chk("R11 16KB even payload", lk_data, 32'h1111_0000);
        chk("R11 16KB even offset", lk_off, 32'h2ABC);
        look(32'h4000_8000, 8'h22);
        chk("R12 outside pair misses", lk_miss, 1);
        chk("R12 outside pair no hit", lk_hit, 0);
        look(32'h4000_4123, 8'h23);
        chk("R10 ASID mismatch misses", lk_miss, 1);
        look(32'h9234_5678, 8'h22);
        chk("R10 256MB index", lk_idx, 6);
        chk("R11 256MB payload", lk_data, 32'h4444);
        chk("R11 256MB offset", lk_off, 32'h0234_5678);
        look(32'hA000_0000, 8'h22);
        chk("R12 beyond 256MB pair misses", lk_miss, 1);
        look(32'h0010_1FFF, 8'h01);
        chk("R11 4KB odd payload", lk_data, 32'hB000_0000);
        chk("R11 4KB offset", lk_off, 32'h0FFF);
        chk("R13 single match not multi", lk_multi, 0);
        @(negedge clk);
        lk_valid = 1'b0;
        #1;
        chk("R12 idle no miss", lk_miss, 0);
        chk("R12 idle no hit", lk_hit, 0);
    endtask

    task automatic t_search;
        sp_cap = 1'b0; sp_en = 1'b0;
        search(32'h0010_4003);
        chk("R9 exact hit", sel, 32'h2);
        search(32'h0010_5803);
        chk("R9 low VPN bits ignored", sel, 32'h2);
        search(32'h0010_4004);
        chk("R9 ASID miss code", sel, 32'h8000_0000);
        search(32'h0010_8003);
        chk("R9 VPN miss code", sel, 32'h8000_0000);
        search(32'h4000_6022);
        chk("R9 16KB entry hit", sel, 32'h5);
    endtask

    task automatic t_small;
        sp_cap = 1'b1; sp_en = 1'b1;
        put(32'h7, 32'h5000_0801, 32'h0, 32'h55, 32'h66);
        look(32'h5000_0C05, 8'h01);
        chk("R10 1KB hit index", lk_idx, 7);
        chk("R11 1KB odd payload", lk_data, 32'h66);
        chk("R11 1KB offset", lk_off, 32'h005);
        look(32'h5000_0405, 8'h01);
        chk("R10 1KB neighbour pair misses", lk_miss, 1);
        lk_valid = 1'b0;
        search(32'h5000_0801);
        chk("R9 small mode exact", sel, 32'h7);
        search(32'h5000_0001);
        chk("R7 small mode keeps low VPN bits", sel, 32'h8000_0000);
        sp_en = 1'b0;
        search(32'h5000_0001);
        chk("R7 normal mode ignores low VPN bits", sel, 32'h7);
    endtask

    task automatic t_illegal;
        sp_cap = 1'b0; sp_en = 1'b0;
        put(32'h3, 32'h0777_0005, 32'h0000_2800, 32'h0, 32'h0);
        chk("R8 err raised", err, 1);
        @(negedge clk);
        chk("R8 err single cycle", err, 0);
        load(32'h3);
        chk("R8 entry unchanged", tag, 32'h0010_6004);
        put(32'h3, 32'h0777_0005, 32'h0000_3800, 32'h0, 32'h0);
        chk("R8 mask 0x7 rejected", err, 1);
        put(32'h3, 32'h0777_0005, 32'h0001_F800, 32'h0, 32'h0);
        chk("R8 legal mask no err", err, 0);
        load(32'h3);
        chk("R8 legal store lands", tag, 32'h0777_0005);
        chk("R6 legal mask readback", size, 32'h0001_E000);
    endtask

    task automatic t_multi;
        put(32'h0, 32'h7000_0009, 32'h0, 32'h0, 32'h0);
        put(32'h1, 32'h7000_0009, 32'h0, 32'h0, 32'h0);
        look(32'h7000_0010, 8'h09);
        chk("R13 multi flag", lk_multi, 1);
        chk("R13 hit with multi", lk_hit, 1);
        chk("R13 lowest index", lk_idx, 0);
        lk_valid = 1'b0;
        search(32'h7000_0009);
        chk("R9 lowest slot on search", sel, 32'h0);
    endtask

    task automatic t_random;
        logic [2:0] r;
        @(negedge clk);
        r = rnd;
        @(negedge clk);
        chk("R4 counts down", rnd, (r == 3'd0) ? 3'd7 : r - 3'd1);
        wr_reg(3'd1, 32'h6600_0044); wr_reg(3'd2, 32'h0);
        wr_reg(3'd3, 32'h77); wr_reg(3'd4, 32'h88);
        @(negedge clk);
        r = rnd;
        cmd_valid = 1'b1; cmd_op = 2'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        look(32'h6600_0000, 8'h44);
        chk("R4 random slot used", lk_idx, r);
        chk("R4 random store hit", lk_hit, 1);
        lk_valid = 1'b0;
        load(32'(r));
        chk("R4 random slot readback", tag, 32'h6600_0044);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_store_load();
        t_size_mode();
        t_lookup();
        t_search();
        t_small();
        t_illegal();
        t_multi();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule